// File: doc/BRIEF.md
# Serial Audio Link Halt and Wake Sequencer

This block is the controller-side sequencer that parks a serial audio link in its low-power halted mode and later brings it back. It runs on a free-running system clock. The codec's bit clock arrives raw and is resynchronised inside. A codec-ready flag, already extracted from the input frame, tells the sequencer when the codec can talk again. While the link is up, the frame-sync and serial data-out lines from the frame assembler pass through. At every other time the sequencer owns them.

A park request marks the end of the frame that carried the power-down command. From the next cycle both lines are held low, and a hold-off of four frame times is counted in system-clock cycles, since no bit clock runs. A wake request can arrive during the hold-off; it is remembered and carried out as soon as the hold-off expires. A wake takes one of two forms. A cold wake pulls the active-low codec reset output low for a fixed time, which also clears the codec's registers. A warm wake raises sync for a fixed time with the bit clock stopped and then lowers it, which keeps the codec's registers. The sequencer then waits for bit-clock edges and for the ready flag. A timeout on either wait raises an error flag and sends the link back to halted.

Top module: `link_wake_seq`

## Requirements
- R1: After reset the link is halted: sync_out, sdo_out, link_up and timeout_err are 0 and codec_rst_n is 1.
- R2: While link_up is 1, sync_out equals frm_sync and sdo_out equals frm_sdo in the same cycle.
- R3: From the cycle after an accepted park request, sync_out and sdo_out stay 0 until a wake pulse begins, whatever frm_sync and frm_sdo do. link_up drops in that same cycle.
- R4: After an accepted park request, sync_out stays 0 for HOLD_CYC cycles, where HOLD_CYC is ceil(HOLDOFF_NS*CLK_MHZ/1000). A wake request seen during that time is stored and its pulse starts in the cycle right after the hold-off.
- R5: A warm wake drives sync_out to 1 for exactly WARM_CYC cycles, where WARM_CYC is ceil(WARM_NS*CLK_MHZ/1000), with codec_rst_n held at 1. sync_out then returns to 0.
- R6: A cold wake drives codec_rst_n to 0 for exactly COLD_CYC cycles, where COLD_CYC is ceil(COLD_NS*CLK_MHZ/1000), with sync_out held at 0.
- R7: After a pulse the sequencer waits for edges on bclk_raw and then for codec_rdy. link_up rises only in the cycle after codec_rdy was seen at 1.
- R8: If bit-clock edges, or codec_rdy after them, do not arrive within TIMEOUT_CYC cycles, timeout_err goes to 1 and the link returns to halted. The next accepted wake clears timeout_err.
- R9: A wake request while link_up is 1 has no effect. A park request while the link is not up has no effect; in particular it starts no new hold-off.
- R10: wake_cold is sampled together with wake_req: 1 selects the cold path and 0 selects the warm path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| bclk_raw | input | 1 | Codec bit clock, asynchronous to clk |
| codec_rdy | input | 1 | Codec-ready flag taken from the input frame |
| park_req | input | 1 | One-cycle pulse: the power-down frame has been sent |
| wake_req | input | 1 | One-cycle wake request |
| wake_cold | input | 1 | Wake type sampled with wake_req: 1 cold, 0 warm |
| frm_sync | input | 1 | Frame-sync from the frame assembler |
| frm_sdo | input | 1 | Serial data-out from the frame assembler |
| sync_out | output | 1 | Frame-sync line to the codec |
| sdo_out | output | 1 | Serial data-out line to the codec |
| codec_rst_n | output | 1 | Active-low codec reset |
| link_up | output | 1 | Link active and codec ready |
| timeout_err | output | 1 | Clock or ready flag did not arrive in time |

## Verification
The bench sets CLK_MHZ to 125, HOLDOFF_NS to 800, WARM_NS to 80, COLD_NS to 120, TIMEOUT_CYC to 300 and ABSENT_CYC to 16. This gives a 100-cycle hold-off, a 10-cycle warm pulse and a 15-cycle cold pulse, so every edge of each window can be checked to the exact cycle. The short timeout also makes both timeout paths reachable in a few hundred cycles: the bit clock never coming back, and the ready flag never arriving while the clock runs. A wake stored in the middle of the hold-off and a park request ignored while halted are both visible through when sync_out rises.

// File: rtl/link_wake_pkg.sv
package link_wake_pkg;

   typedef enum logic [2:0] {
      LS_ACTIVE   = 3'd0,
      LS_PARKED   = 3'd1,
      LS_HALTED   = 3'd2,
      LS_WARM     = 3'd3,
      LS_COLD     = 3'd4,
      LS_WAIT_CLK = 3'd5,
      LS_WAIT_RDY = 3'd6
   } lstate_e;

   // nanoseconds to system cycles, rounded up
   function automatic int ns_to_cyc(input int ns, input int mhz);
      return (ns * mhz + 999) / 1000;
   endfunction

endpackage

// File: rtl/wake_timer.sv
module wake_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         done
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (load)         cnt <= load_val;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);
endmodule

// File: rtl/bclk_activity.sv
module bclk_activity #(
   parameter int STAGES     = 2,
   parameter int ABSENT_CYC = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk_raw,
   output logic present
);
   localparam int GW = $clog2(ABSENT_CYC + 1);
   localparam logic [GW-1:0] GAP_SAT = GW'(ABSENT_CYC);

   if (STAGES < 2) begin : g_bad_stages
      $error("bclk_activity: STAGES must be at least 2");
   end
   if (ABSENT_CYC < 2) begin : g_bad_absent
      $error("bclk_activity: ABSENT_CYC must be at least 2");
   end

   logic [STAGES-1:0] sh;
   logic              last;
   logic [GW-1:0]     gap;
   logic              edge_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '0;
         last <= 1'b0;
      end else begin
         sh   <= {sh[STAGES-2:0], bclk_raw};
         last <= sh[STAGES-1];
      end
   end

   assign edge_seen = last ^ sh[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                gap <= GAP_SAT;
      else if (edge_seen)        gap <= '0;
      else if (gap != GAP_SAT)   gap <= gap + 1'b1;
   end

   assign present = (gap != GAP_SAT);
endmodule

// File: rtl/wake_fsm.sv
module wake_fsm import link_wake_pkg::*; #(
   parameter int HOLD_CYC    = 100,
   parameter int WARM_CYC    = 10,
   parameter int COLD_CYC    = 10,
   parameter int TIMEOUT_CYC = 300,
   parameter int TW          = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          park_req,
   input  logic          wake_req,
   input  logic          wake_cold,
   input  logic          clk_present,
   input  logic          codec_rdy,
   input  logic          tmr_done,
   output lstate_e       state,
   output logic          tmr_load,
   output logic [TW-1:0] tmr_val,
   output logic          timeout_err
);
   lstate_e nxt;
   logic    pend, pend_cold;
   logic    launch, launch_cold, set_err;

   assign launch = (state == LS_HALTED && wake_req) ||
                   (state == LS_PARKED && tmr_done && (pend || wake_req));
   assign launch_cold = (state == LS_PARKED && pend) ? pend_cold : wake_cold;

   always_comb begin
      nxt      = state;
      tmr_load = 1'b0;
      tmr_val  = '0;
      set_err  = 1'b0;
      if (launch) begin
         nxt      = launch_cold ? LS_COLD : LS_WARM;
         tmr_load = 1'b1;
         tmr_val  = launch_cold ? TW'(COLD_CYC - 1) : TW'(WARM_CYC - 1);
      end else begin
         case (state)
            LS_ACTIVE: if (park_req) begin
               nxt      = LS_PARKED;
               tmr_load = 1'b1;
               tmr_val  = TW'(HOLD_CYC - 1);
            end
            LS_PARKED: if (tmr_done) nxt = LS_HALTED;
            LS_WARM, LS_COLD: if (tmr_done) begin
               nxt      = LS_WAIT_CLK;
               tmr_load = 1'b1;
               tmr_val  = TW'(TIMEOUT_CYC - 1);
            end
            LS_WAIT_CLK: begin
               if (clk_present) begin
                  nxt      = LS_WAIT_RDY;
                  tmr_load = 1'b1;
                  tmr_val  = TW'(TIMEOUT_CYC - 1);
               end else if (tmr_done) begin
                  nxt     = LS_HALTED;
                  set_err = 1'b1;
               end
            end
            LS_WAIT_RDY: begin
               if (codec_rdy) nxt = LS_ACTIVE;
               else if (tmr_done) begin
                  nxt     = LS_HALTED;
                  set_err = 1'b1;
               end
            end
            LS_HALTED: nxt = LS_HALTED;
            default:   nxt = LS_HALTED;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= LS_HALTED;
         pend        <= 1'b0;
         pend_cold   <= 1'b0;
         timeout_err <= 1'b0;
      end else begin
         state <= nxt;
         if (state != LS_PARKED) begin
            pend      <= 1'b0;
            pend_cold <= 1'b0;
         end else if (wake_req && !pend) begin
            pend      <= 1'b1;
            pend_cold <= wake_cold;
         end
         if (launch)       timeout_err <= 1'b0;
         else if (set_err) timeout_err <= 1'b1;
      end
   end
endmodule

// File: rtl/link_wake_seq.sv
module link_wake_seq import link_wake_pkg::*; #(
   parameter int CLK_MHZ     = 125,
   parameter int HOLDOFF_NS  = 83334,
   parameter int WARM_NS     = 1000,
   parameter int COLD_NS     = 1000,
   parameter int TIMEOUT_CYC = 4096,
   parameter int ABSENT_CYC  = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk_raw,
   input  logic codec_rdy,
   input  logic park_req,
   input  logic wake_req,
   input  logic wake_cold,
   input  logic frm_sync,
   input  logic frm_sdo,
   output logic sync_out,
   output logic sdo_out,
   output logic codec_rst_n,
   output logic link_up,
   output logic timeout_err
);
   localparam int HOLD_CYC  = ns_to_cyc(HOLDOFF_NS, CLK_MHZ);
   localparam int WARM_CYC  = ns_to_cyc(WARM_NS, CLK_MHZ);
   localparam int COLD_CYC  = ns_to_cyc(COLD_NS, CLK_MHZ);
   localparam int PULSE_MAX = (WARM_CYC > COLD_CYC) ? WARM_CYC : COLD_CYC;
   localparam int SPAN_MAX  = (HOLD_CYC > TIMEOUT_CYC) ? HOLD_CYC : TIMEOUT_CYC;
   localparam int CNT_MAX   = (PULSE_MAX > SPAN_MAX) ? PULSE_MAX : SPAN_MAX;
   localparam int TW        = $clog2(CNT_MAX + 1);

   if (CLK_MHZ < 1) begin : g_bad_clk
      $error("link_wake_seq: CLK_MHZ must be positive");
   end
   if (HOLD_CYC < 1 || WARM_CYC < 1 || COLD_CYC < 1) begin : g_bad_time
      $error("link_wake_seq: every timed window needs at least one cycle");
   end
   if (TIMEOUT_CYC < 2) begin : g_bad_tmo
      $error("link_wake_seq: TIMEOUT_CYC must be at least 2");
   end

   lstate_e       state;
   logic          clk_present;
   logic          tmr_load, tmr_done;
   logic [TW-1:0] tmr_val;

   bclk_activity #(
      .STAGES     (SYNC_STAGES),
      .ABSENT_CYC (ABSENT_CYC)
   ) u_act (
      .clk      (clk),
      .rst_n    (rst_n),
      .bclk_raw (bclk_raw),
      .present  (clk_present)
   );

   wake_timer #(.W(TW)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .done     (tmr_done)
   );

   wake_fsm #(
      .HOLD_CYC    (HOLD_CYC),
      .WARM_CYC    (WARM_CYC),
      .COLD_CYC    (COLD_CYC),
      .TIMEOUT_CYC (TIMEOUT_CYC),
      .TW          (TW)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .park_req    (park_req),
      .wake_req    (wake_req),
      .wake_cold   (wake_cold),
      .clk_present (clk_present),
      .codec_rdy   (codec_rdy),
      .tmr_done    (tmr_done),
      .state       (state),
      .tmr_load    (tmr_load),
      .tmr_val     (tmr_val),
      .timeout_err (timeout_err)
   );

   assign link_up     = (state == LS_ACTIVE);
   assign sync_out    = (link_up && frm_sync) || (state == LS_WARM);
   assign sdo_out     = link_up && frm_sdo;
   assign codec_rst_n = (state != LS_COLD);
endmodule

// File: rtl/link_wake_chk.sv
module link_wake_chk #(
   parameter int HOLD_CYC = 1,
   parameter int WARM_CYC = 1,
   parameter int COLD_CYC = 1
) (
   input logic clk,
   input logic rst_n,
   input logic park_req,
   input logic codec_rdy,
   input logic link_up,
   input logic sync_out,
   input logic sdo_out,
   input logic codec_rst_n,
   input logic timeout_err
);
   int hold_left, warm_run, cold_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_left <= 0;
         warm_run  <= 0;
         cold_run  <= 0;
      end else begin
         if (park_req && link_up) hold_left <= HOLD_CYC;
         else if (hold_left != 0) hold_left <= hold_left - 1;
         warm_run <= (sync_out && !link_up) ? warm_run + 1 : 0;
         cold_run <= !codec_rst_n ? cold_run + 1 : 0;
      end
   end

   assert_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !link_up |-> !sdo_out);

   assert_holdoff_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hold_left != 0 |-> !sync_out);

   assert_warm_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_out && !link_up && warm_run != 0) |-> warm_run == WARM_CYC);

   assert_cold_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (codec_rst_n && cold_run != 0) |-> cold_run == COLD_CYC);

   assert_cold_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !codec_rst_n |-> (!sync_out && !link_up));

   assert_up_after_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_up) |-> $past(codec_rdy));

   assert_err_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_err |-> !link_up);
endmodule

bind link_wake_seq link_wake_chk #(
   .HOLD_CYC (HOLD_CYC),
   .WARM_CYC (WARM_CYC),
   .COLD_CYC (COLD_CYC)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .park_req    (park_req),
   .codec_rdy   (codec_rdy),
   .link_up     (link_up),
   .sync_out    (sync_out),
   .sdo_out     (sdo_out),
   .codec_rst_n (codec_rst_n),
   .timeout_err (timeout_err)
);

// File: tb/tb_link_wake_seq.sv
module tb_link_wake_seq;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bclk = 1'b0;
   logic bclk_en = 1'b0;
   logic codec_rdy = 1'b0;
   logic park_req = 1'b0;
   logic wake_req = 1'b0;
   logic wake_cold = 1'b0;
   logic frm_sync = 1'b0;
   logic frm_sdo = 1'b0;
   logic sync_out, sdo_out, codec_rst_n, link_up, timeout_err;
   logic [4:0] ov;
   int cyc = 0;
   int total = 0;
   int bad = 0;

   // expected-item queues (scoreboard)
   int         qc[$];
   logic [4:0] qv[$];
   string      qr[$];

   link_wake_seq #(
      .CLK_MHZ(125), .HOLDOFF_NS(800), .WARM_NS(80), .COLD_NS(120),
      .TIMEOUT_CYC(300), .ABSENT_CYC(16), .SYNC_STAGES(2)
   ) dut (
      .clk(clk), .rst_n(rst_n), .bclk_raw(bclk), .codec_rdy(codec_rdy),
      .park_req(park_req), .wake_req(wake_req), .wake_cold(wake_cold),
      .frm_sync(frm_sync), .frm_sdo(frm_sdo), .sync_out(sync_out),
      .sdo_out(sdo_out), .codec_rst_n(codec_rst_n), .link_up(link_up),
      .timeout_err(timeout_err)
   );

   // vector: {link_up, sync_out, sdo_out, codec_rst_n, timeout_err}
   assign ov = {link_up, sync_out, sdo_out, codec_rst_n, timeout_err};

   always #4 clk = ~clk;
   always begin
      #16;
      if (bclk_en) bclk = ~bclk;
   end
   always @(posedge clk) cyc <= cyc + 1;

   task automatic expect_at(input int c, input logic [4:0] v, input string r);
      qc.push_back(c);
      qv.push_back(v);
      qr.push_back(r);
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wait_until(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic wait_up();
      for (int i = 0; i < 300; i++) begin
         if (link_up) break;
         @(negedge clk);
      end
   endtask

   task automatic finish_run();
      if (qc.size() != 0) begin
         bad++;
         total++;
         $display("FAIL %s pending=%0d expected=0", qr[0], qc.size());
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   // monitor: samples 2 ns after each rising edge
   always @(posedge clk) begin
      int c;
      logic [4:0] v;
      string r;
      #2;
      while (qc.size() > 0 && qc[0] <= cyc) begin
         c = qc.pop_front();
         v = qv.pop_front();
         r = qr.pop_front();
         total++;
         if (c != cyc || ov !== v) begin
            bad++;
            $display("FAIL %s cyc=%0d due=%0d actual=%b expected=%b", r, cyc, c, ov, v);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      int n, m;
      repeat (5) step();
      rst_n = 1'b1;
      step();
      expect_at(cyc + 1, 5'b00010, "R1 reset state");
      step(); step();

      // cold wake from halted (R6, R10)
      n = cyc;
      wake_req = 1'b1; wake_cold = 1'b1;
      expect_at(n + 1,  5'b00000, "R10 cold path chosen");
      expect_at(n + 15, 5'b00000, "R6 cold pulse last cycle");
      expect_at(n + 16, 5'b00010, "R6 cold pulse ends");
      step();
      wake_req = 1'b0; wake_cold = 1'b0;
      wait_until(n + 20);
      bclk_en = 1'b1;
      repeat (30) step();
      expect_at(cyc + 1, 5'b00010, "R7 no link without ready");
      step();
      codec_rdy = 1'b1;
      wait_up();
      expect_at(cyc + 1, 5'b10010, "R7 link up after ready");
      step(); step();

      // pass-through while active (R2)
      frm_sync = 1'b1; frm_sdo = 1'b0;
      expect_at(cyc + 1, 5'b11010, "R2 sync follows framer");
      step(); step();
      frm_sync = 1'b0; frm_sdo = 1'b1;
      expect_at(cyc + 1, 5'b10110, "R2 sdo follows framer");
      step(); step();

      // wake while active is ignored (R9)
      n = cyc;
      wake_req = 1'b1; wake_cold = 1'b1;
      expect_at(n + 1, 5'b10110, "R9 wake ignored while up");
      expect_at(n + 3, 5'b10110, "R9 still up after wake");
      step();
      wake_req = 1'b0; wake_cold = 1'b0;
      wait_until(n + 4);

      // park with a warm wake stored during hold-off (R3, R4, R5)
      frm_sync = 1'b1; frm_sdo = 1'b1;
      n = cyc;
      park_req = 1'b1;
      expect_at(n + 1,   5'b00010, "R3 lines low after park");
      expect_at(n + 100, 5'b00010, "R4 hold-off last cycle");
      expect_at(n + 101, 5'b01010, "R4 stored wake starts");
      expect_at(n + 110, 5'b01010, "R5 warm pulse last cycle");
      expect_at(n + 111, 5'b00010, "R5 warm pulse ends");
      step();
      park_req = 1'b0; bclk_en = 1'b0; codec_rdy = 1'b0;
      wait_until(n + 30);
      wake_req = 1'b1; wake_cold = 1'b0;
      step();
      wake_req = 1'b0;
      wait_until(n + 115);
      bclk_en = 1'b1;
      repeat (20) step();
      codec_rdy = 1'b1;
      wait_up();
      expect_at(cyc + 1, 5'b11110, "R7 up again after warm wake");
      step(); step();

      // park with no wake: halts; park while halted ignored (R3, R9, R8)
      frm_sync = 1'b0; frm_sdo = 1'b0;
      n = cyc;
      park_req = 1'b1;
      expect_at(n + 100, 5'b00010, "R3 parked lines low");
      expect_at(n + 101, 5'b00010, "R3 halted lines low");
      step();
      park_req = 1'b0; bclk_en = 1'b0; codec_rdy = 1'b0;
      wait_until(n + 105);
      m = cyc;
      park_req = 1'b1;
      step();
      park_req = 1'b0; wake_req = 1'b1; wake_cold = 1'b0;
      expect_at(m + 2,   5'b01010, "R9 park while halted no hold-off");
      expect_at(m + 11,  5'b01010, "R5 warm pulse width");
      expect_at(m + 12,  5'b00010, "R5 sync back low");
      expect_at(m + 311, 5'b00010, "R8 waiting for clock");
      expect_at(m + 312, 5'b00011, "R8 clock timeout flagged");
      step();
      wake_req = 1'b0;
      wait_until(m + 315);

      // cold wake clears error; then ready never comes (R8)
      n = cyc;
      wake_req = 1'b1; wake_cold = 1'b1;
      expect_at(n + 1, 5'b00000, "R8 error cleared by wake");
      step();
      wake_req = 1'b0; wake_cold = 1'b0;
      wait_until(n + 20);
      bclk_en = 1'b1;
      repeat (400) step();
      expect_at(cyc + 1, 5'b00011, "R8 ready timeout flagged");
      repeat (4) step();
      finish_run();
   end
endmodule